// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block keeps the pending-interrupt flags of a small 8-bit controller in three byte-wide registers placed at offsets 0, 1 and 2. Each of the 24 flags has a request line. A one-cycle pulse on that line from a peripheral sets the flag. The flag stays set until the CPU acknowledges that source by index, or until software clears it.

Software reaches the flags through a simple write port that carries a size code, and through a combinational read port. A write can change one bit, one whole byte, or the two lower registers together as a 16-bit word. The bank drives the full flag vector to the priority logic, together with one pending line. Two positions behave differently from the rest:

- Flag 23 is a test input. It latches its request, but it never counts as pending.
- Flag 0 belongs to the watchdog. It can only be written or set while the watchdog runs as an interval timer.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, all 24 flags, `rd_data` and `irq_pending` are 0.
- R2: A 1 on `hw_req[i]` sets flag i at the next clock edge. Flag i sits at bit i%8 of the register at offset i/8.
- R3: When `ack_valid` is 1 and `ack_idx` < 24, flag `ack_idx` clears at the next edge and the other flags are unchanged. An index of 24 or above changes nothing.
- R4: A hardware request always wins. If `hw_req[i]` is 1 in the same cycle as an acknowledge or a software write that clears flag i, flag i is 1 afterwards.
- R5: A byte write (`wr_size`=2'b01) to offset 0, 1 or 2 loads `wr_data[7:0]` into that register. A byte write to offset 3 has no effect.
- R6: A bit write (`wr_size`=2'b00) sets bit `wr_bit` of the register at `wr_addr` to `wr_data[0]` and leaves every other flag unchanged. A bit write to offset 3 has no effect.
- R7: A word write (`wr_size`=2'b10) at offset 0 loads `wr_data[7:0]` into offset 0 and `wr_data[15:8]` into offset 1, and leaves offset 2 unchanged. A word write at any other offset, and any write with `wr_size`=2'b11, has no effect.
- R8: Bits 3 to 6 of the register at offset 2 (flags 19 to 22) always read 0, whatever is written or requested.
- R9: While `wdt_interval` is 0, flag 0 is 0 at the next edge, whatever is requested or written. While `wdt_interval` is 1, flag 0 behaves like any other flag.
- R10: `irq_pending` is 1 exactly when any of flags 0 to 18 is 1. Flag 23 alone never raises it.
- R11: `rd_data` shows the register at `rd_addr` in the same cycle, and shows 0 for offset 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_interval | input | 1 | 1 = watchdog runs as interval timer |
| hw_req | input | 24 | One-cycle set pulses, one per flag |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 5 | Index of the flag being acknowledged |
| wr_en | input | 1 | Software write strobe |
| wr_size | input | 2 | 00 bit, 01 byte, 10 word, 11 none |
| wr_addr | input | 2 | Register offset of the write |
| wr_bit | input | 3 | Bit position for a bit write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Register offset to read |
| rd_data | output | 8 | Read data |
| flags | output | 24 | Flag vector |
| irq_pending | output | 1 | Any vectorable flag set |

## Verification
The assertions check the following on every cycle:

- the reserved flags stay zero;
- the watchdog flag stays clear outside interval mode;
- any valid request leaves its flag set;
- an acknowledge without a competing request clears exactly its flag;
- a lone test flag does not raise the pending line.

Other behaviours only show up in the bench's scenarios. These are the byte, word and bit write paths and their ignored offsets, the fact that a bit write leaves its neighbours intact, and the read mux. The bench's reference model, driven by mixed random traffic, also covers the three-way collisions between a write, an acknowledge and a request.

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int NREG = 3,
  parameter int WDT_BIT = 0,
  parameter int TEST_BIT = 23,
  parameter logic [NREG*8-1:0] RSVD_MASK = 24'h78_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wdt_interval,
  input  logic [NREG*8-1:0]           hw_req,
  input  logic                        ack_valid,
  input  logic [$clog2(NREG*8)-1:0]   ack_idx,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_size,
  input  logic [$clog2(NREG+1)-1:0]   wr_addr,
  input  logic [2:0]                  wr_bit,
  input  logic [15:0]                 wr_data,
  input  logic [$clog2(NREG+1)-1:0]   rd_addr,
  output logic [7:0]                  rd_data,
  output logic [NREG*8-1:0]           flags,
  output logic                        irq_pending
);
  localparam int NF = NREG * 8;
  localparam logic [1:0] SZ_BIT  = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [NF-1:0] TEST_MASK = NF'(1) << TEST_BIT;
  localparam logic [NF-1:0] VEC_MASK  = ~(RSVD_MASK | TEST_MASK);

  logic [NF-1:0] flag_q, wr_mask, wr_val, ack_mask, flag_d;
  logic          wr_in_range;

  assign wr_in_range = int'(wr_addr) < NREG;

  always_comb begin
    wr_mask = '0;
    wr_val  = '0;
    if (wr_en) begin
      case (wr_size)
        SZ_BIT: if (wr_in_range) begin
          wr_mask[int'(wr_addr) * 8 + int'(wr_bit)] = 1'b1;
          wr_val[int'(wr_addr) * 8 + int'(wr_bit)]  = wr_data[0];
        end
        SZ_BYTE: if (wr_in_range) begin
          wr_mask[int'(wr_addr) * 8 +: 8] = 8'hFF;
          wr_val[int'(wr_addr) * 8 +: 8]  = wr_data[7:0];
        end
        SZ_WORD: if (wr_addr == '0) begin
          wr_mask[15:0] = 16'hFFFF;
          wr_val[15:0]  = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ack_mask = '0;
    if (ack_valid && int'(ack_idx) < NF) ack_mask[ack_idx] = 1'b1;
  end

  always_comb begin
    flag_d = ((((flag_q & ~wr_mask) | (wr_val & wr_mask)) & ~ack_mask) | hw_req) & ~RSVD_MASK;
    if (!wdt_interval) flag_d[WDT_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags       = flag_q;
  assign irq_pending = |(flag_q & VEC_MASK);
  assign rd_data     = (int'(rd_addr) < NREG) ? flag_q[int'(rd_addr) * 8 +: 8] : 8'h00;
endmodule

module irq_flag_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wdt_interval,
  input logic [23:0] hw_req,
  input logic        ack_valid,
  input logic [4:0]  ack_idx,
  input logic [23:0] flags,
  input logic        irq_pending
);
  localparam logic [23:0] SET_MASK = 24'h87_FFFE;

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[22:19] == 4'h0);

  // R9
  wdt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_interval |=> !flags[0]);

  // R2
  req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_req & SET_MASK)) |=> ((flags & $past(hw_req & SET_MASK)) == $past(hw_req & SET_MASK)));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_idx < 5'd24 && ack_idx != 5'd0 && !hw_req[ack_idx]) |=> !flags[$past(ack_idx)]);

  // R10
  test_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 24'h80_0000) |-> !irq_pending);
endmodule

bind irq_flag_bank irq_flag_bank_chk chk (
  .clk(clk), .rst_n(rst_n), .wdt_interval(wdt_interval), .hw_req(hw_req),
  .ack_valid(ack_valid), .ack_idx(ack_idx), .flags(flags), .irq_pending(irq_pending)
);

// File: tb/irq_flag_bank_test.sv
`timescale 1ns/1ps
module irq_flag_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt_interval = 1'b1;
  logic [23:0] hw_req = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_idx = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_size = '0;
  logic [1:0]  wr_addr = '0;
  logic [2:0]  wr_bit = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [23:0] flags;
  logic        irq_pending;

  int total = 0;
  int bad = 0;
  logic [23:0] exp_flags = '0;

  always #4 clk = ~clk;

  irq_flag_bank uut (
    .clk(clk), .rst_n(rst_n), .wdt_interval(wdt_interval), .hw_req(hw_req),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .wr_en(wr_en), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_bit(wr_bit), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .flags(flags), .irq_pending(irq_pending)
  );

  function automatic logic [23:0] model(input logic [23:0] cur);
    logic [23:0] nx = cur;
    if (wr_en) begin
      if (wr_size == 2'b00 && wr_addr != 2'd3) nx[int'(wr_addr) * 8 + int'(wr_bit)] = wr_data[0];
      if (wr_size == 2'b01 && wr_addr != 2'd3) nx[int'(wr_addr) * 8 +: 8] = wr_data[7:0];
      if (wr_size == 2'b10 && wr_addr == 2'd0) nx[15:0] = wr_data;
    end
    if (ack_valid && ack_idx < 5'd24) nx[ack_idx] = 1'b0;
    nx = nx | hw_req;
    nx[22:19] = 4'h0;
    if (!wdt_interval) nx[0] = 1'b0;
    return nx;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [23:0] f, input logic [1:0] a);
    return (a == 2'd3) ? 8'h00 : f[int'(a) * 8 +: 8];
  endfunction

  task automatic check(input string tag);
    total++;
    if (flags !== exp_flags || irq_pending !== (|exp_flags[18:0]) ||
        rd_data !== exp_rd(exp_flags, rd_addr)) begin
      bad++;
      $display("FAIL %s: flags=%h pend=%b rd=%h expected flags=%h pend=%b rd=%h",
               tag, flags, irq_pending, rd_data, exp_flags, |exp_flags[18:0],
               exp_rd(exp_flags, rd_addr));
    end
  endtask

  task automatic idle();
    hw_req = '0; ack_valid = 1'b0; ack_idx = '0; wr_en = 1'b0;
    wr_size = '0; wr_addr = '0; wr_bit = '0; wr_data = '0;
  endtask

  task automatic cyc(input string tag);
    exp_flags = model(exp_flags);
    @(posedge clk);
    @(negedge clk);
    idle();
    check(tag);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [1:0] a, input logic [2:0] b,
                    input logic [15:0] d, input string tag);
    wr_en = 1'b1; wr_size = sz; wr_addr = a; wr_bit = b; wr_data = d;
    cyc(tag);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state");
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 check("R1 read after reset");
    end
    rd_addr = 2'd0;

    hw_req = 24'h00_0020; cyc("R2 single request");
    hw_req = 24'h84_0102; cyc("R2 several requests incl test flag");
    rd_addr = 2'd2; #1 check("R11 read offset 2");
    rd_addr = 2'd1; #1 check("R11 read offset 1");
    rd_addr = 2'd3; #1 check("R11 read offset 3 zero");

    wr(2'b01, 2'd0, 3'd0, 16'h0000, "R5 byte clear offset 0");
    wr(2'b01, 2'd1, 3'd0, 16'h0000, "R5 byte clear offset 1");
    rd_addr = 2'd2;
    wr(2'b01, 2'd2, 3'd0, 16'h0000, "R5 byte clear offset 2");
    check("R10 nothing pending");

    hw_req = 24'h80_0000; cyc("R10 test flag only");
    if (irq_pending !== 1'b0) begin bad++; $display("FAIL R10: pend=%b expected 0", irq_pending); end
    total++;
    hw_req = 24'h00_0008; cyc("R10 vectorable flag pending");

    wr(2'b01, 2'd2, 3'd0, 16'h00FF, "R8 byte write to reserved bits");
    hw_req = 24'h78_0000; cyc("R8 requests on reserved bits");
    wr(2'b01, 2'd3, 3'd0, 16'h00FF, "R5 byte write to offset 3 ignored");

    wr(2'b00, 2'd1, 3'd4, 16'h0001, "R6 bit set");
    wr(2'b00, 2'd2, 3'd7, 16'h0000, "R6 bit clear keeps neighbours");
    wr(2'b00, 2'd3, 3'd2, 16'h0001, "R6 bit write offset 3 ignored");

    wr(2'b10, 2'd0, 3'd0, 16'hA55A, "R7 word write offset 0");
    wr(2'b10, 2'd1, 3'd0, 16'hFFFF, "R7 word write offset 1 ignored");
    wr(2'b11, 2'd0, 3'd0, 16'hFFFF, "R7 size 11 ignored");

    ack_valid = 1'b1; ack_idx = 5'd3; cyc("R3 ack clears one flag");
    ack_valid = 1'b1; ack_idx = 5'd30; cyc("R3 out-of-range ack ignored");
    ack_valid = 1'b1; ack_idx = 5'd9; hw_req = 24'h00_0200; cyc("R4 request beats ack");
    hw_req = 24'h00_0400; wr_en = 1'b1; wr_size = 2'b00; wr_addr = 2'd1; wr_bit = 3'd2;
    wr_data = 16'h0000; cyc("R4 request beats bit clear");

    wdt_interval = 1'b0;
    hw_req = 24'h00_0001; cyc("R9 request in watchdog mode");
    wr(2'b01, 2'd0, 3'd0, 16'h00FF, "R9 write in watchdog mode");
    wdt_interval = 1'b1;
    wr(2'b00, 2'd0, 3'd0, 16'h0001, "R9 bit write in interval mode");
    hw_req = 24'h00_0001; cyc("R9 request in interval mode");

    for (int i = 0; i < 3000; i++) begin
      hw_req = 24'($urandom & $urandom & $urandom);
      ack_valid = ($urandom % 3) == 0;
      ack_idx = 5'($urandom);
      wr_en = ($urandom % 4) == 0;
      wr_size = 2'($urandom);
      wr_addr = 2'($urandom);
      wr_bit = 3'($urandom);
      wr_data = 16'($urandom);
      rd_addr = 2'($urandom);
      if (($urandom % 50) == 0) wdt_interval = ~wdt_interval;
      cyc("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule